// File: doc/BRIEF.md
# TDM Frame Demultiplexer

This block takes a serial stream in the 32-slot, 2.048 Mb/s time-division format and splits it back into byte-wide channel samples. A frame lasts 125 µs and carries 256 bits: 32 timeslots of 8 bits. Slot 0 carries frame alignment and slot 16 carries signalling. The other 30 slots carry one 64 kb/s payload channel each.

The stream arrives one bit per system clock cycle in which `ser_valid` is high, with the most significant bit of each slot first. The block first hunts for the alignment word at every bit phase. Once it has a candidate, it waits for the same word at the same phase in the next frame, and only then declares lock. While locked, it checks slot 0 of every frame, and it returns to the hunt after three bad frames in a row. Each completed payload byte comes out with its slot number and a one-cycle strobe. The slot-16 byte goes to a separate signalling port.

Top module: `tdm_frame_demux`

## Requirements
- R1: After reset, `in_lock`, `ch_valid` and `sig_valid` are low.
- R2: In the hunt, the alignment word (default 8'h1B) is accepted at any bit phase. This gives a candidate, and `in_lock` rises one clock after the last bit of the same word arriving exactly 256 stream bits later.
- R3: If a candidate is not followed, 256 bits later, by the alignment word, the block returns to the hunt without locking. It can take a new candidate in a later frame.
- R4: While locked, an alignment-word pattern inside payload or signalling bytes does not disturb lock or frame phase.
- R5: While locked, a bad slot-0 byte in three consecutive frames drops `in_lock` one clock after the last bit of the third bad byte. A correct slot-0 byte clears the count of bad frames.
- R6: `ch_valid` and `sig_valid` are asserted only while `in_lock` is high. No byte from a hunting or candidate frame is presented.
- R7: Each byte of slots 1–15 and 17–31 appears on `ch_data`, with `ch_idx` equal to the slot number (1..31, never 0 or 16). `ch_valid` is high for exactly the one clock after the byte's eighth bit is taken.
- R8: The slot-16 byte appears on `sig_data` with a one-clock `sig_valid`, at the same relative time, and never on the channel port.
- R9: The first bit received in a slot becomes bit 7 of the presented byte.
- R10: Cycles with `ser_valid` low, whatever `ser_bit` holds, neither advance the bit count nor enter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Serial line bit |
| ser_valid | input | 1 | High in cycles carrying a new line bit |
| in_lock | output | 1 | Frame alignment is held |
| ch_valid | output | 1 | One-cycle strobe for a payload byte |
| ch_idx | output | 5 | Slot number of the payload byte |
| ch_data | output | 8 | Payload byte |
| sig_valid | output | 1 | One-cycle strobe for the slot-16 byte |
| sig_data | output | 8 | Signalling byte |

## Verification
While locked, pattern matching against the alignment word runs on every bit. A payload byte whose value is the alignment word therefore raises a match in the same cycle that completes a payload delivery. The bench provokes this by placing the word in slot 5 and slot 16 of a locked frame. It judges the result by requiring that both bytes are delivered with the right slot number and timestamp, and that `in_lock` still holds at the next frame. A second overlap occurs when a bad-frame count update coincides with the bytes that frame still delivers. Bad frames are interleaved with one good frame, and every payload byte of the bad frames must still reach the scoreboard.

// File: rtl/tdmx_pkg.sv
package tdmx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CANDID  = 2'd1,
    ST_LOCKED  = 2'd2
  } align_state_e;

  // next bit position within a frame, wrapping at frame_bits
  function automatic int unsigned pos_step(int unsigned pos, int unsigned frame_bits);
    return (pos + 1 == frame_bits) ? 0 : pos + 1;
  endfunction

  // true when a slot number is a payload slot
  function automatic bit slot_is_payload(int unsigned slot, int unsigned sig_slot);
    return (slot != 0) && (slot != sig_slot);
  endfunction
endpackage

// File: rtl/tdmx_shifter.sv
module tdmx_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  output logic [WIDTH-1:0] window
);
  logic [WIDTH-1:0] q;

  // window is the byte including the bit being taken this cycle, MSB first
  assign window = {q[WIDTH-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= window;
  end
endmodule

// File: rtl/tdmx_pos_counter.sv
module tdmx_pos_counter #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned LOAD_VAL   = 8,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  output logic [POS_W-1:0] pos
);
  import tdmx_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos <= '0;
    else if (en) begin
      if (load) pos <= POS_W'(LOAD_VAL);
      else      pos <= POS_W'(pos_step(int'(pos), FRAME_BITS));
    end
  end

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pos));
endmodule

// File: rtl/tdmx_align_fsm.sv
module tdmx_align_fsm #(
  parameter int unsigned MISS_LIMIT = 3,
  localparam int unsigned MISS_W    = $clog2(MISS_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic match,
  input  logic at_ts0_end,
  output logic load_pos,
  output logic locked
);
  import tdmx_pkg::*;

  align_state_e      state_q, state_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              last_miss;

  assign last_miss = (miss_q == MISS_W'(MISS_LIMIT - 1));
  assign load_pos  = en && (state_q == ST_HUNT) && match;
  assign locked    = (state_q == ST_LOCKED);

  always_comb begin
    state_d = state_q;
    miss_d  = miss_q;
    if (en) begin
      unique case (state_q)
        ST_HUNT:   if (match) state_d = ST_CANDID;
        ST_CANDID: if (at_ts0_end) begin
          state_d = match ? ST_LOCKED : ST_HUNT;
          miss_d  = '0;
        end
        ST_LOCKED: if (at_ts0_end) begin
          if (match) miss_d = '0;
          else if (last_miss) begin
            state_d = ST_HUNT;
            miss_d  = '0;
          end else miss_d = miss_q + 1'b1;
        end
        default:   state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
    end
  end

  assert_lock_needs_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state_q == ST_CANDID && en && at_ts0_end && match));
  assert_loss_after_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(en && at_ts0_end && !match && last_miss));
  assert_no_hunt_to_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) |=> !locked);
endmodule

// File: rtl/tdm_frame_demux.sv
module tdm_frame_demux #(
  parameter int unsigned SLOT_BITS  = 8,
  parameter int unsigned SLOTS      = 32,
  parameter int unsigned SIG_SLOT   = 16,
  parameter int unsigned MISS_LIMIT = 3,
  parameter logic [7:0]  ALIGN_WORD = 8'h1B,
  localparam int unsigned FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int unsigned POS_W      = $clog2(FRAME_BITS),
  localparam int unsigned BIT_W      = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W     = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_bit,
  input  logic                 ser_valid,
  output logic                 in_lock,
  output logic                 ch_valid,
  output logic [SLOT_W-1:0]    ch_idx,
  output logic [SLOT_BITS-1:0] ch_data,
  output logic                 sig_valid,
  output logic [SLOT_BITS-1:0] sig_data
);
  import tdmx_pkg::*;

  logic [SLOT_BITS-1:0] window;
  logic [POS_W-1:0]     pos;
  logic [SLOT_W-1:0]    slot;
  logic                 match, at_ts0_end, byte_end, load_pos;
  logic                 take_payload, take_sig;

  tdmx_shifter #(.WIDTH(SLOT_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ser_valid), .din(ser_bit), .window(window));

  tdmx_pos_counter #(.FRAME_BITS(FRAME_BITS), .LOAD_VAL(SLOT_BITS)) u_pos (
    .clk(clk), .rst_n(rst_n), .en(ser_valid), .load(load_pos), .pos(pos));

  tdmx_align_fsm #(.MISS_LIMIT(MISS_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(ser_valid), .match(match),
    .at_ts0_end(at_ts0_end), .load_pos(load_pos), .locked(in_lock));

  // named events, visible to assertions
  assign match        = (window == ALIGN_WORD[SLOT_BITS-1:0]);
  assign slot         = pos[POS_W-1:BIT_W];
  assign byte_end     = (pos[BIT_W-1:0] == {BIT_W{1'b1}});
  assign at_ts0_end   = (pos == POS_W'(SLOT_BITS - 1));
  assign take_payload = ser_valid && in_lock && byte_end &&
                        slot_is_payload(int'(slot), SIG_SLOT);
  assign take_sig     = ser_valid && in_lock && byte_end &&
                        (slot == SLOT_W'(SIG_SLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_valid  <= 1'b0;
      ch_idx    <= '0;
      ch_data   <= '0;
      sig_valid <= 1'b0;
      sig_data  <= '0;
    end else begin
      ch_valid  <= take_payload;
      sig_valid <= take_sig;
      if (take_payload) begin
        ch_idx  <= slot;
        ch_data <= window;
      end
      if (take_sig) sig_data <= window;
    end
  end

  assert_strobe_only_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid || sig_valid) |-> in_lock);
  assert_sig_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_valid && sig_valid));
  assert_idx_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> (ch_idx != '0 && ch_idx != SLOT_W'(SIG_SLOT)));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |=> !ch_valid);
  assert_payload_keeps_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lock && ser_valid && match && !at_ts0_end) |=> in_lock);
endmodule

// File: tb/test_tdm_frame_demux.sv
module test_tdm_frame_demux;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [7:0] ALIGN = 8'h1B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_bit = 1'b0;
  logic ser_valid = 1'b0;
  logic in_lock, ch_valid, sig_valid;
  logic [4:0] ch_idx;
  logic [7:0] ch_data, sig_data;

  tdm_frame_demux i_tdm_frame_demux (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .in_lock(in_lock), .ch_valid(ch_valid), .ch_idx(ch_idx), .ch_data(ch_data),
    .sig_valid(sig_valid), .sig_data(sig_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit         sig;
    logic [4:0] idx;
    logic [7:0] data;
    int         stamp;
  } exp_item_t;

  exp_item_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int bitno = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [7:0] byte_for(int f, int s);
    return 8'((f * 37 + s * 11 + 5) & 8'hFF);
  endfunction

  // one line bit, MSB first; idle gaps carry the inverted bit (R10)
  task automatic drive_bit(logic b, bit push, exp_item_t it);
    exp_item_t t;
    @(negedge clk);
    ser_valid = 1'b1;
    ser_bit   = b;
    if (push) begin
      t = it;
      t.stamp = cyc;
      exp_q.push_back(t);
    end
    @(negedge clk);
    ser_valid = 1'b0;
    ser_bit   = ~b;
    repeat (bitno % 3) @(negedge clk);
    bitno++;
  endtask

  task automatic send_byte(logic [7:0] v, bit push, bit sig, int slot);
    exp_item_t it;
    it.sig = sig; it.idx = 5'(slot); it.data = v; it.stamp = 0;
    for (int i = 7; i >= 0; i--) drive_bit(v[i], push && (i == 0), it);
  endtask

  task automatic send_frame(int fid, logic [7:0] ts0, bit filler, bit expect_out,
                            logic lock_exp, string tag);
    logic [7:0] v;
    send_byte(ts0, 1'b0, 1'b0, 0);
    chk(in_lock === lock_exp, $sformatf("%s frame %0d in_lock act=%b exp=%b",
        tag, fid, in_lock, lock_exp));
    for (int s = 1; s < 32; s++) begin
      if (filler) v = 8'hFF;
      else if (fid == 2 && (s == 5 || s == 16)) v = ALIGN;  // R4 pattern in payload
      else v = byte_for(fid, s);
      send_byte(v, expect_out, (s == 16), s);
    end
  endtask

  // scoreboard monitor: R6 R7 R8 R9
  always @(negedge clk) begin
    exp_item_t e;
    if (rst_n && !done) begin
      if (ch_valid && sig_valid) begin
        chk(1'b0, "R8 both strobes act=11 exp=one");
      end else if (ch_valid || sig_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, $sformatf("R6 unexpected strobe ch=%b sig=%b idx=%0d exp=none",
              ch_valid, sig_valid, ch_idx));
        end else begin
          e = exp_q.pop_front();
          if (e.sig)
            chk(sig_valid && sig_data == e.data && cyc == e.stamp + 1,
                $sformatf("R8 sig act v=%b d=%h t=%0d exp d=%h t=%0d",
                sig_valid, sig_data, cyc, e.data, e.stamp + 1));
          else
            chk(ch_valid && ch_idx == e.idx && ch_data == e.data && cyc == e.stamp + 1,
                $sformatf("R7/R9 ch act v=%b idx=%0d d=%h t=%0d exp idx=%0d d=%h t=%0d",
                ch_valid, ch_idx, ch_data, cyc, e.idx, e.data, e.stamp + 1));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(!in_lock && !ch_valid && !sig_valid,
        $sformatf("R1 reset act=%b%b%b exp=000", in_lock, ch_valid, sig_valid));
    rst_n = 1'b1;
    for (int k = 0; k < 37; k++) drive_bit(1'b1, 1'b0, '{0, 0, 0, 0});  // odd phase offset
    chk(!in_lock, $sformatf("R2 hunting act=%b exp=0", in_lock));
    send_frame(0,  ALIGN, 1, 0, 1'b0, "R2 candidate");
    send_frame(1,  ALIGN, 0, 1, 1'b1, "R2 lock");
    send_frame(2,  ALIGN, 0, 1, 1'b1, "R4 pattern");
    send_frame(3,  8'h00, 0, 1, 1'b1, "R5 miss1");
    send_frame(4,  8'h00, 0, 1, 1'b1, "R5 miss2");
    send_frame(5,  ALIGN, 0, 1, 1'b1, "R4 after pattern");
    send_frame(6,  8'h00, 0, 1, 1'b1, "R5 count cleared");
    send_frame(7,  8'h00, 0, 1, 1'b1, "R5 miss2 again");
    send_frame(8,  8'h00, 1, 0, 1'b0, "R5 loss");
    send_frame(9,  ALIGN, 1, 0, 1'b0, "R3 candidate");
    send_frame(10, 8'h00, 1, 0, 1'b0, "R3 confirm fail");
    send_frame(11, ALIGN, 1, 0, 1'b0, "R3 new candidate");
    send_frame(12, ALIGN, 0, 1, 1'b1, "R3 relock");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, $sformatf("R6 R7 leftover act=%0d exp=0", exp_q.size()));
    chk(!ch_valid && !sig_valid, "R10 idle strobes act=1 exp=0");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule